// File: doc/BRIEF.md
# Dual-Enable Watchdog Timer

This block is a watchdog counter clocked by its own low-power clock, kept apart from the system clock so that it keeps counting when the system clock is halted. It runs when either a fixed configuration input is high or, with that input low, a software enable bit is high. Software keeps it quiet by sending a clear pulse before the count reaches the end of its period.

When the period runs out, the watchdog raises one of two requests, chosen by the power state it sees. With the processor running, it raises a one-cycle reset request. With the processor in Sleep, it raises a one-cycle wake request instead. Both cases set a sticky timeout flag. A timeout during Sleep also sets a sticky sleep flag.

All controls from the system domain cross into the watchdog domain through two-flop synchronisers. The clear and status-clear pulses are carried across as toggles. The configuration enable is expected to be tied high on an unprogrammed part.

Top module: `wdog_dual_en`

## Requirements
- R1: The count advances on `wd_clk` alone; timeouts keep occurring while `sys_clk` is stopped, as long as the enable and the power state are unchanged.
- R2: With `cfg_en` = 1 the watchdog runs whatever the value of `sw_en`.
- R3: With `cfg_en` = 0 the watchdog runs exactly when `sw_en` = 1; with both at 0, no request is ever raised.
- R4: While continuously enabled and never cleared, timeouts repeat every 2^(CNT_W+PRE_W) `wd_clk` cycles (64 with the defaults), and the count wraps to zero after each one.
- R5: A one-cycle `clr` pulse on `sys_clk` restarts the count. Pulses spaced well inside the period prevent every timeout.
- R6: A timeout with `sleep` = 0 raises `rst_req` for exactly one `wd_clk` cycle, sets `to_flag`, and leaves `slp_flag` unchanged.
- R7: A timeout with `sleep` = 1 raises `wake_req` for one `wd_clk` cycle and no `rst_req`, and sets both `to_flag` and `slp_flag`.
- R8: `to_flag` and `slp_flag` stay set until a `sts_clr` pulse on `sys_clk` or a `por_n` reset. A timeout in the same cycle as the clear wins.
- R9: Removing the enable zeroes the count, so after re-enabling, a full period passes before the next timeout.
- R10: While `por_n` = 0 all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may stop during Sleep |
| wd_clk | input | 1 | Independent low-power watchdog clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_en | input | 1 | Configuration enable; forces the watchdog on when 1 |
| sw_en | input | 1 | Software enable, used only when cfg_en is 0 |
| sleep | input | 1 | Power state: 1 = processor in Sleep |
| clr | input | 1 | One sys_clk pulse that restarts the count |
| sts_clr | input | 1 | One sys_clk pulse that clears both status flags |
| rst_req | output | 1 | One wd_clk pulse: device reset request |
| wake_req | output | 1 | One wd_clk pulse: wake from Sleep request |
| to_flag | output | 1 | Sticky timeout flag |
| slp_flag | output | 1 | Sticky flag for a timeout during Sleep |

## Verification
A count register that is wrong shows up as a change in the spacing of requests. That spacing is measured against the 64-cycle period, so an error of one tick is caught on the next timeout. A broken enable or clear path shows up as a request where none may appear, or as a missing one, within about one period. A wrong power-state choice or flag update is visible at the ports on the cycle of the timeout itself, and it stays visible in the sticky flags until they are cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    TMO_NONE  = 2'd0,
    TMO_RESET = 2'd1,
    TMO_WAKE  = 2'd2
  } tmo_kind_e;

  function automatic tmo_kind_e tmo_kind(input logic hit, input logic asleep);
    if (!hit) return TMO_NONE;
    return asleep ? TMO_WAKE : TMO_RESET;
  endfunction
endpackage

// File: rtl/wdog_bit_sync.sv
module wdog_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/wdog_pulse_xfer.sv
module wdog_pulse_xfer (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  logic tog, tog_s, tog_d;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (src_pulse) tog <= ~tog;
  end

  wdog_bit_sync #(.W(1)) u_sync (
    .clk(dst_clk), .rst_n(rst_n), .d(tog), .q(tog_s)
  );

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else tog_d <= tog_s;
  end

  assign dst_pulse = tog_s ^ tog_d;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PRE_W = 2
) (
  input  logic wd_clk,
  input  logic rst_n,
  input  logic run,
  input  logic asleep,
  input  logic clr,
  input  logic sts_clr,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag,
  output logic slp_flag
);
  localparam int PW = (PRE_W > 0) ? PRE_W : 1;

  logic [PW-1:0]    pre;
  logic [CNT_W-1:0] cnt;
  logic             tick, hit;
  tmo_kind_e        kind;

  generate
    if (PRE_W > 0) begin : g_pre
      assign tick = &pre;
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign hit  = run && !clr && tick && (&cnt);
  assign kind = tmo_kind(hit, asleep);

  always_ff @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      cnt      <= '0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
      slp_flag <= 1'b0;
    end else begin
      rst_req  <= (kind == TMO_RESET);
      wake_req <= (kind == TMO_WAKE);
      if (!run || clr) begin
        pre <= '0;
        cnt <= '0;
      end else begin
        pre <= pre + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
      end
      if (kind != TMO_NONE) begin
        to_flag <= 1'b1;
        if (kind == TMO_WAKE) slp_flag <= 1'b1;
      end else if (sts_clr) begin
        to_flag  <= 1'b0;
        slp_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdog_dual_en.sv
module wdog_dual_en #(
  parameter int CNT_W = 4,
  parameter int PRE_W = 2
) (
  input  logic sys_clk,
  input  logic wd_clk,
  input  logic por_n,
  input  logic cfg_en,
  input  logic sw_en,
  input  logic sleep,
  input  logic clr,
  input  logic sts_clr,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag,
  output logic slp_flag
);
  logic [2:0] lvl_s;
  logic       core_run, clr_wd, sts_clr_wd;

  wdog_bit_sync #(.W(3)) u_lvl (
    .clk(wd_clk), .rst_n(por_n), .d({sleep, sw_en, cfg_en}), .q(lvl_s)
  );

  assign core_run = lvl_s[0] | lvl_s[1];

  wdog_pulse_xfer u_clr (
    .src_clk(sys_clk), .dst_clk(wd_clk), .rst_n(por_n),
    .src_pulse(clr), .dst_pulse(clr_wd)
  );

  wdog_pulse_xfer u_sts (
    .src_clk(sys_clk), .dst_clk(wd_clk), .rst_n(por_n),
    .src_pulse(sts_clr), .dst_pulse(sts_clr_wd)
  );

  wdog_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .wd_clk(wd_clk), .rst_n(por_n), .run(core_run), .asleep(lvl_s[2]),
    .clr(clr_wd), .sts_clr(sts_clr_wd),
    .rst_req(rst_req), .wake_req(wake_req),
    .to_flag(to_flag), .slp_flag(slp_flag)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic wd_clk,
  input logic por_n,
  input logic rst_req,
  input logic wake_req,
  input logic to_flag,
  input logic slp_flag,
  input logic run,
  input logic sts_clr_p
);
  a_r6_rst_one_cycle: assert property (@(posedge wd_clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  a_r6_rst_sets_to: assert property (@(posedge wd_clk) disable iff (!por_n)
    rst_req |-> to_flag);
  a_r7_wake_sets_flags: assert property (@(posedge wd_clk) disable iff (!por_n)
    wake_req |-> (to_flag && slp_flag));
  a_r7_one_request_kind: assert property (@(posedge wd_clk) disable iff (!por_n)
    !(rst_req && wake_req));
  a_r3_idle_quiet: assert property (@(posedge wd_clk) disable iff (!por_n)
    !run |=> (!rst_req && !wake_req));
  a_r8_flag_sticky: assert property (@(posedge wd_clk) disable iff (!por_n)
    (to_flag && !sts_clr_p) |=> to_flag);
endmodule

bind wdog_dual_en wdog_chk u_chk (
  .wd_clk(wd_clk), .por_n(por_n), .rst_req(rst_req), .wake_req(wake_req),
  .to_flag(to_flag), .slp_flag(slp_flag), .run(core_run), .sts_clr_p(sts_clr_wd)
);

// File: tb/sim_wdog_dual_en.sv
`timescale 1ns/1ps
module sim_wdog_dual_en;
  localparam int CNT_W = 4;
  localparam int PRE_W = 2;

  logic sys_clk = 1'b0, wd_clk = 1'b0, sys_on = 1'b1;
  logic por_n = 1'b0, cfg_en = 1'b0, sw_en = 1'b0, sleep = 1'b0;
  logic clr = 1'b0, sts_clr = 1'b0;
  logic rst_req, wake_req, to_flag, slp_flag;

  int total = 0, bad = 0;
  int cyc = 0, rst_seen = 0, wake_seen = 0, last_rst = 0, last_int = 0, wide = 0;
  logic rst_prev = 1'b0, wake_prev = 1'b0;

  always #5 if (sys_on) sys_clk = ~sys_clk; else sys_clk = 1'b0;
  always #17 wd_clk = ~wd_clk;

  wdog_dual_en #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u0 (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .por_n(por_n), .cfg_en(cfg_en),
    .sw_en(sw_en), .sleep(sleep), .clr(clr), .sts_clr(sts_clr),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag), .slp_flag(slp_flag)
  );

  function automatic int period();
    return 1 << (CNT_W + PRE_W);
  endfunction

  function automatic logic exp_run(input logic c, input logic s);
    return c | s;
  endfunction

  always @(negedge wd_clk) begin
    cyc++;
    if (rst_req) begin
      if (rst_prev) wide++;
      if (rst_seen > 0) last_int = cyc - last_rst;
      last_rst = cyc;
      rst_seen++;
    end
    if (wake_req) begin
      if (wake_prev) wide++;
      wake_seen++;
    end
    rst_prev = rst_req;
    wake_prev = wake_req;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_wd(input int n);
    for (int i = 0; i < n; i++) @(posedge wd_clk);
  endtask

  task automatic zero_counts();
    @(posedge wd_clk);
    rst_seen = 0; wake_seen = 0; last_int = 0; wide = 0;
  endtask

  task automatic sys_pulse(input bit which);
    @(negedge sys_clk);
    if (which) sts_clr = 1'b1; else clr = 1'b1;
    @(negedge sys_clk);
    sts_clr = 1'b0; clr = 1'b0;
  endtask

  task automatic idle_all();
    cfg_en = 1'b0; sw_en = 1'b0; sleep = 1'b0;
    wait_wd(10);
    sys_pulse(1'b1);
    wait_wd(8);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    #40;
    // R10: reset state
    check("R10 rst_req", rst_req, 0);
    check("R10 wake_req", wake_req, 0);
    check("R10 flags", {to_flag, slp_flag}, 0);
    #13 por_n = 1'b1;
    wait_wd(4);

    // R2 + R4 + R6: cfg_en forces run, periodic reset requests
    cfg_en = 1'b1; sw_en = 1'b0;
    zero_counts();
    wait_wd(3 * period() + 10);
    check("R2 resets seen", rst_seen >= 3, 1);
    check("R4 period", last_int, period());
    check("R6 one-cycle pulse", wide, 0);
    check("R6 no wake", wake_seen, 0);
    check("R6 to_flag", to_flag, 1);
    check("R6 slp_flag", slp_flag, 0);

    // R8: flags clear on sts_clr
    idle_all();
    check("R8 cleared", {to_flag, slp_flag}, 0);

    // R3: both enables off -> nothing
    zero_counts();
    wait_wd(3 * period());
    check("R3 disabled quiet", rst_seen + wake_seen, 0);

    // R3: software enable alone runs it
    sw_en = 1'b1;
    zero_counts();
    wait_wd(period() + 10);
    check("R3 sw_en runs", rst_seen >= 1, 1);

    // R5: periodic clears hold off timeouts
    idle_all();
    cfg_en = 1'b1;
    zero_counts();
    for (int k = 0; k < 10; k++) begin
      wait_wd(period() / 2);
      sys_pulse(1'b0);
    end
    check("R5 no timeout with clears", rst_seen, 0);
    wait_wd(period() + 10);
    check("R5 timeout after clears stop", rst_seen >= 1, 1);

    // R9: disabling zeroes the count
    idle_all();
    cfg_en = 1'b1;
    wait_wd(period() - 20);
    cfg_en = 1'b0;
    wait_wd(10);
    cfg_en = 1'b1;
    zero_counts();
    wait_wd(period() - 10);
    check("R9 full period after re-enable", rst_seen, 0);
    wait_wd(20);
    check("R9 timeout later", rst_seen, 1);

    // R7 + R1: sleep timeout with system clock stopped
    idle_all();
    sleep = 1'b1;
    wait_wd(3);
    cfg_en = 1'b1;
    wait_wd(3);
    sys_on = 1'b0;
    zero_counts();
    wait_wd(2 * period() + 10);
    check("R1 counts with sys_clk stopped", wake_seen >= 2, 1);
    check("R7 no reset in sleep", rst_seen, 0);
    check("R7 flags", {to_flag, slp_flag}, 2'b11);
    check("R7 one-cycle wake", wide, 0);
    sys_on = 1'b1;
    cfg_en = 1'b0;
    wait_wd(2 * period());
    check("R8 sticky", {to_flag, slp_flag}, 2'b11);
    sys_pulse(1'b1);
    wait_wd(6);
    check("R8 cleared by sts_clr", {to_flag, slp_flag}, 0);

    // Random rounds: R2 R3 R6 R7
    for (int r = 0; r < 12; r++) begin
      logic c, s, sl, en;
      c = 1'($urandom); s = 1'($urandom); sl = 1'($urandom);
      idle_all();
      sleep = sl;
      wait_wd(4);
      cfg_en = c; sw_en = s;
      zero_counts();
      wait_wd(period() + 20);
      en = exp_run(c, s);
      check("R3 random reset count", rst_seen > 0, int'(en && !sl));
      check("R7 random wake count", wake_seen > 0, int'(en && sl));
      check("R6 random flags", {to_flag, slp_flag}, en ? {1'b1, sl} : 2'b00);
    end

    // R10: reset clears flags
    cfg_en = 1'b1; sleep = 1'b1;
    wait_wd(period() + 20);
    por_n = 1'b0;
    #5;
    check("R10 por clears", {to_flag, slp_flag, rst_req, wake_req}, 0);
    summary();
  end
endmodule